// File: doc/BRIEF.md
# Monochrome-to-Colour Expansion Write Unit

This block turns a one-bit-per-pixel host write into colour pixel data for a packed framebuffer. Each bitmap bit picks one of two colours: a set bit gives the foreground colour, a clear bit the background colour. A byte access expands to 8 pixels and a 16-bit access to 16 pixels. The target is either one byte per pixel (256-colour) or two 4-bit pixels per byte (16-colour). With expansion off, the host data goes through as ordinary byte stores.

The result is presented as a stream of nibbles. Nibble `n` is byte `n/2`, low half when `n` is even. It leaves in beats of 8 bytes (`out_data` lane `k` is byte `8*beat+k`), each nibble with its own write enable. A split option for 16-colour expansion moves every pixel up by one nibble. The first pixel then lands in the upper half of the even byte, the next in the lower half of the following byte, and so on. That option is only legal for 16-bit accesses at even addresses.

A small state machine has the states IDLE, BEAT0, BEAT1 and FAULT. Its transitions are:
- IDLE to BEAT0 on an accepted legal request.
- IDLE to FAULT on an accepted illegal split request.
- BEAT0 to BEAT1 when a second beat is needed.
- BEAT0, BEAT1 or FAULT back to IDLE on the last beat with no new request.
- From the last beat straight to BEAT0 or FAULT when a new request is taken in that cycle.

Top module: `mono_color_expander`

## Requirements
- R1: With `exp_en`=0 the access passes through. Lane 0 gets `host_data[7:0]` with `out_nib_en`=0x0003. A 16-bit access also puts `host_data[15:8]` in lane 1, giving enables 0x000F. This is one beat, and `mode_256`, `split_en` and `addr_odd` have no effect on it.
- R2: During expansion, a bitmap bit of 1 produces `fg_color` for its pixel and a bit of 0 produces `bg_color`.
- R3: A byte access (`wide_access`=0) expands `host_data[7:0]` to 8 pixels. A 16-bit access expands `host_data[15:0]` to 16 pixels. Pixel p (p=0 is leftmost, lowest address) takes bitmap bit N-1-p, where N is the pixel count.
- R4: With `mode_256`=1, pixel p occupies the whole byte p with the full 8-bit colour. 8 pixels fill one beat; 16 pixels take two beats.
- R5: With `mode_256`=0 and `split_en`=0, pixel p occupies nibble p using colour bits 3:0 only. This gives enables 0x00FF for 8 pixels and 0xFFFF for 16 pixels, in one beat.
- R6: In split mode (`exp_en`=1, `mode_256`=0, `split_en`=1, 16-bit, even address), pixel p occupies nibble p+1. Beat 0 carries nibbles 1..15 (enables 0xFFFE). Beat 1 carries only nibble 16 (enables 0x0001).
- R7: A split request that is odd-addressed or 8-bit produces a single beat with `out_err`=1, `out_last`=1, no nibble enables and zero data.
- R8: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. Its first beat is valid in the next cycle and any second beat in the cycle after that. `out_last` marks the final beat. `req_ready` is 1 when idle or on a final beat, and 0 on a first beat that has a successor.
- R9: During and right after reset, `out_valid`=0, `req_ready`=1, `out_nib_en`=0 and `out_err`=0.
- R10: `split_en` has no effect when `exp_en`=0 or `mode_256`=1, whatever `addr_odd` is.
- R11: Nibbles without an enable carry zero data, and all outputs are zero while `out_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host write request present |
| req_ready | output | 1 | Request will be taken at the next edge |
| host_data | input | 16 | Bitmap or pass-through data |
| addr_odd | input | 1 | Access starts at an odd address |
| wide_access | input | 1 | 16-bit access when 1, byte access when 0 |
| exp_en | input | 1 | Colour expansion enable |
| mode_256 | input | 1 | Byte-per-pixel target when 1, packed nibbles when 0 |
| split_en | input | 1 | Shift nibble pixels by one nibble |
| fg_color | input | 8 | Colour for set bitmap bits |
| bg_color | input | 8 | Colour for clear bitmap bits |
| out_valid | output | 1 | A beat is presented |
| out_data | output | 64 | Eight output byte lanes |
| out_nib_en | output | 16 | Write enable per nibble, bit 2k is the low nibble of lane k |
| out_beat | output | 1 | 0 for bytes 0..7, 1 for bytes 8..15 |
| out_last | output | 1 | Final beat of the request |
| out_err | output | 1 | Illegal split request rejected |

## Verification
The checker watches the handshake and beat sequencing on every cycle:
- a taken request yields a first beat next cycle;
- a second beat always follows a non-final first beat;
- a rejected request is always a silent, final beat;
- the idle outputs stay quiet.

Only the bench's scenarios can show the pixel contents: bit-to-pixel order, colour choice, the nibble packing and the one-nibble shift of split mode. They can also show that `split_en` is ignored in the modes where it does not apply.

// File: rtl/mce_pkg.sv
package mce_pkg;

    localparam int HOST_W      = 16;                       // bitmap bits per wide access
    localparam int COLOR_W     = 8;                        // colour register width
    localparam int NIB_W       = 4;                        // packed pixel width
    localparam int STREAM_NIBS = HOST_W * COLOR_W / NIB_W; // nibbles for 16 byte pixels
    localparam int BEAT_NIBS   = STREAM_NIBS / 2;          // nibbles per output beat
    localparam int BEAT_W      = BEAT_NIBS * NIB_W;        // data bits per beat

    typedef enum logic [1:0] {
        XM_PASS,
        XM_BYTE,
        XM_NIBBLE,
        XM_FAULT
    } xmode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BEAT0,
        ST_BEAT1,
        ST_FAULT
    } st_e;

    typedef struct packed {
        xmode_e              mode;
        logic                wide;
        logic                shift;
        logic [HOST_W-1:0]   bits;
        logic [COLOR_W-1:0]  fg;
        logic [COLOR_W-1:0]  bg;
    } xreq_t;

    // Returns {in_range, bitmap_bit} for pixel index p; leftmost pixel is the MSB.
    function automatic logic [1:0] pick_bit(logic [HOST_W-1:0] bits, logic wide, int p);
        int npix;
        npix = wide ? HOST_W : HOST_W / 2;
        if (p < 0 || p >= npix) begin
            return 2'b00;
        end
        return {1'b1, bits[npix-1-p]};
    endfunction

endpackage

// File: rtl/mce_decode.sv
module mce_decode
    import mce_pkg::*;
(
    input  logic                exp_en_i,
    input  logic                mode256_i,
    input  logic                split_i,
    input  logic                addr_odd_i,
    input  logic                wide_i,
    input  logic [HOST_W-1:0]   data_i,
    input  logic [COLOR_W-1:0]  fg_i,
    input  logic [COLOR_W-1:0]  bg_i,
    output xreq_t               req_o,
    output logic                two_beat_o
);

    always_comb begin
        req_o.wide  = wide_i;
        req_o.bits  = data_i;
        req_o.fg    = fg_i;
        req_o.bg    = bg_i;
        req_o.shift = 1'b0;
        if (!exp_en_i) begin
            req_o.mode = XM_PASS;
        end else if (mode256_i) begin
            req_o.mode = XM_BYTE;
        end else if (split_i && (addr_odd_i || !wide_i)) begin
            req_o.mode = XM_FAULT;
        end else begin
            req_o.mode  = XM_NIBBLE;
            req_o.shift = split_i;
        end
        two_beat_o = ((req_o.mode == XM_BYTE) && wide_i) ||
                     ((req_o.mode == XM_NIBBLE) && req_o.shift);
    end

endmodule

// File: rtl/mce_pixgen.sv
module mce_pixgen
    import mce_pkg::*;
(
    input  xreq_t                          req_i,
    output logic [STREAM_NIBS*NIB_W-1:0]   nib_o,
    output logic [STREAM_NIBS-1:0]         nib_en_o
);

    for (genvar n = 0; n < STREAM_NIBS; n++) begin : g_nib
        localparam int  BYTE_IX = n / 2;
        localparam bit  HI_HALF = (n % 2) == 1;

        logic [NIB_W-1:0]   pass_val;
        logic               pass_en;
        logic [NIB_W-1:0]   nv;
        logic               ne;
        logic [1:0]         pk;
        logic [COLOR_W-1:0] col;

        if (BYTE_IX < HOST_W / 8) begin : g_lane
            assign pass_val = req_i.bits[n*NIB_W +: NIB_W];
            assign pass_en  = (BYTE_IX == 0) || req_i.wide;
        end else begin : g_nolane
            assign pass_val = '0;
            assign pass_en  = 1'b0;
        end

        always_comb begin
            nv  = '0;
            ne  = 1'b0;
            pk  = 2'b00;
            col = req_i.bg;
            unique case (req_i.mode)
                XM_PASS: begin
                    ne = pass_en;
                    nv = pass_en ? pass_val : '0;
                end
                XM_BYTE: begin
                    pk  = pick_bit(req_i.bits, req_i.wide, BYTE_IX);
                    col = pk[0] ? req_i.fg : req_i.bg;
                    if (pk[1]) begin
                        ne = 1'b1;
                        nv = HI_HALF ? col[NIB_W +: NIB_W] : col[0 +: NIB_W];
                    end
                end
                XM_NIBBLE: begin
                    pk  = pick_bit(req_i.bits, req_i.wide, n - int'(req_i.shift));
                    col = pk[0] ? req_i.fg : req_i.bg;
                    if (pk[1]) begin
                        ne = 1'b1;
                        nv = col[0 +: NIB_W];
                    end
                end
                XM_FAULT: begin
                end
            endcase
        end

        assign nib_o[n*NIB_W +: NIB_W] = nv;
        assign nib_en_o[n]             = ne;
    end

endmodule

// File: rtl/mce_fsm.sv
module mce_fsm
    import mce_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid_i,
    input  logic fault_i,
    input  logic two_beat_i,
    output logic req_ready_o,
    output logic take_o,
    output logic out_valid_o,
    output logic out_last_o,
    output logic out_beat_o,
    output logic out_err_o
);

    st_e  st_q, st_d;
    logic two_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            two_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (take_o) begin
                two_q <= two_beat_i;
            end
        end
    end

    // outputs and handshake
    always_comb begin
        out_valid_o = 1'b0;
        out_last_o  = 1'b0;
        out_beat_o  = 1'b0;
        out_err_o   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
            end
            ST_BEAT0: begin
                out_valid_o = 1'b1;
                out_last_o  = !two_q;
            end
            ST_BEAT1: begin
                out_valid_o = 1'b1;
                out_last_o  = 1'b1;
                out_beat_o  = 1'b1;
            end
            ST_FAULT: begin
                out_valid_o = 1'b1;
                out_last_o  = 1'b1;
                out_err_o   = 1'b1;
            end
        endcase
        req_ready_o = (st_q == ST_IDLE) || out_last_o;
        take_o      = req_valid_i && req_ready_o;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (take_o) begin
            st_d = fault_i ? ST_FAULT : ST_BEAT0;
        end else begin
            unique case (st_q)
                ST_IDLE:  st_d = ST_IDLE;
                ST_BEAT0: st_d = two_q ? ST_BEAT1 : ST_IDLE;
                ST_BEAT1: st_d = ST_IDLE;
                ST_FAULT: st_d = ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mono_color_expander.sv
module mono_color_expander
    import mce_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [HOST_W-1:0]   host_data,
    input  logic                addr_odd,
    input  logic                wide_access,
    input  logic                exp_en,
    input  logic                mode_256,
    input  logic                split_en,
    input  logic [COLOR_W-1:0]  fg_color,
    input  logic [COLOR_W-1:0]  bg_color,
    output logic                out_valid,
    output logic [BEAT_W-1:0]   out_data,
    output logic [BEAT_NIBS-1:0] out_nib_en,
    output logic                out_beat,
    output logic                out_last,
    output logic                out_err
);

    xreq_t                        req_d, req_q;
    logic                         two_d;
    logic                         take;
    logic [STREAM_NIBS*NIB_W-1:0] nib_all;
    logic [STREAM_NIBS-1:0]       en_all;

    mce_decode u_decode (
        .exp_en_i   (exp_en),
        .mode256_i  (mode_256),
        .split_i    (split_en),
        .addr_odd_i (addr_odd),
        .wide_i     (wide_access),
        .data_i     (host_data),
        .fg_i       (fg_color),
        .bg_i       (bg_color),
        .req_o      (req_d),
        .two_beat_o (two_d)
    );

    mce_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .fault_i     (req_d.mode == XM_FAULT),
        .two_beat_i  (two_d),
        .req_ready_o (req_ready),
        .take_o      (take),
        .out_valid_o (out_valid),
        .out_last_o  (out_last),
        .out_beat_o  (out_beat),
        .out_err_o   (out_err)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
        end else if (take) begin
            req_q <= req_d;
        end
    end

    mce_pixgen u_pixgen (
        .req_i    (req_q),
        .nib_o    (nib_all),
        .nib_en_o (en_all)
    );

    assign out_data   = !out_valid ? '0 :
                        (out_beat ? nib_all[BEAT_W +: BEAT_W] : nib_all[0 +: BEAT_W]);
    assign out_nib_en = !out_valid ? '0 :
                        (out_beat ? en_all[BEAT_NIBS +: BEAT_NIBS] : en_all[0 +: BEAT_NIBS]);

endmodule

// File: rtl/mce_chk.sv
module mce_chk
    import mce_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 out_valid,
    input logic [BEAT_NIBS-1:0] out_nib_en,
    input logic                 out_beat,
    input logic                 out_last,
    input logic                 out_err
);

    // R8
    accept_to_beat0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (out_valid && !out_beat));

    // R8
    beat1_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_beat) |-> $past(out_valid && !out_beat && !out_last));

    // R8
    no_orphan_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> (out_valid && out_beat));

    // R8
    ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid || out_last) == req_ready);

    // R7
    fault_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (out_nib_en == '0 && out_last && !out_beat));

    // R11
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_nib_en == '0 && !out_err && !out_last && !out_beat));

endmodule

bind mono_color_expander mce_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .out_valid  (out_valid),
    .out_nib_en (out_nib_en),
    .out_beat   (out_beat),
    .out_last   (out_last),
    .out_err    (out_err)
);

// File: tb/mono_color_expander_tb_top.sv
`timescale 1ns/1ps
module mono_color_expander_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] host_data = '0;
    logic        addr_odd = 1'b0;
    logic        wide_access = 1'b0;
    logic        exp_en = 1'b0;
    logic        mode_256 = 1'b0;
    logic        split_en = 1'b0;
    logic [7:0]  fg_color = '0;
    logic [7:0]  bg_color = '0;
    logic        out_valid;
    logic [63:0] out_data;
    logic [15:0] out_nib_en;
    logic        out_beat;
    logic        out_last;
    logic        out_err;

    int n_checks = 0;
    int n_errors = 0;

    typedef struct {
        logic [63:0] d;
        logic [15:0] en;
        logic        beat;
        logic        last;
        logic        err;
        string       tag;
    } exp_t;

    exp_t sbq[$];

    always #4 clk = ~clk;

    mono_color_expander dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .host_data   (host_data),
        .addr_odd    (addr_odd),
        .wide_access (wide_access),
        .exp_en      (exp_en),
        .mode_256    (mode_256),
        .split_en    (split_en),
        .fg_color    (fg_color),
        .bg_color    (bg_color),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_nib_en  (out_nib_en),
        .out_beat    (out_beat),
        .out_last    (out_last),
        .out_err     (out_err)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Expected beats computed from the requirements.
    task automatic push_expect(input bit e, input bit m, input bit s, input bit o, input bit w,
                               input logic [15:0] data, input logic [7:0] fg, input logic [7:0] bg,
                               input string tag, output int nb);
        logic [127:0] sd;
        logic [31:0]  se;
        logic [7:0]   c;
        bit           fault;
        int           npix;
        int           sh;
        exp_t         it;
        sd = '0; se = '0; fault = 1'b0; npix = w ? 16 : 8; nb = 1;
        if (!e) begin
            sd[7:0] = data[7:0]; se[1:0] = 2'b11;
            if (w) begin sd[15:8] = data[15:8]; se[3:2] = 2'b11; end
        end else if (m) begin
            for (int p = 0; p < npix; p++) begin
                c = data[npix-1-p] ? fg : bg;
                sd[8*p +: 8] = c; se[2*p +: 2] = 2'b11;
            end
            nb = w ? 2 : 1;
        end else if (s && (o || !w)) begin
            fault = 1'b1;
        end else begin
            sh = s ? 1 : 0;
            for (int p = 0; p < npix; p++) begin
                c = data[npix-1-p] ? fg : bg;
                sd[4*(p+sh) +: 4] = c[3:0]; se[p+sh] = 1'b1;
            end
            nb = s ? 2 : 1;
        end
        for (int k = 0; k < nb; k++) begin
            it.d    = sd[64*k +: 64];
            it.en   = se[16*k +: 16];
            it.beat = (k == 1);
            it.last = (k == nb - 1);
            it.err  = fault;
            it.tag  = tag;
            sbq.push_back(it);
        end
    endtask

    // Driver: called at a negedge, returns at the negedge after acceptance.
    task automatic send(input bit e, input bit m, input bit s, input bit o, input bit w,
                        input logic [15:0] data, input logic [7:0] fg, input logic [7:0] bg,
                        input string tag);
        int nb;
        exp_en = e; mode_256 = m; split_en = s; addr_odd = o; wide_access = w;
        host_data = data; fg_color = fg; bg_color = bg; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        push_expect(e, m, s, o, w, data, fg, bg, tag, nb);
        @(negedge clk);
        // R8: ready drops only on a first beat that has a successor
        check(req_ready == (nb == 1), "R8", "ready after accept",
              128'(req_ready), 128'(nb == 1));
    endtask

    // Monitor: compare each presented beat with the scoreboard head.
    always @(negedge clk) begin
        exp_t it;
        if (rst_n && out_valid) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R8", "unexpected beat", 128'(out_nib_en), 128'(0));
            end else begin
                it = sbq.pop_front();
                check({out_data, out_nib_en, out_beat, out_last, out_err} ===
                      {it.d, it.en, it.beat, it.last, it.err}, it.tag, "beat",
                      128'({out_data, out_nib_en, out_beat, out_last, out_err}),
                      128'({it.d, it.en, it.beat, it.last, it.err}));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] rs;
        repeat (3) @(negedge clk);
        // R9 reset state
        check(!out_valid && req_ready && out_nib_en == 0 && !out_err, "R9", "in reset",
              128'({out_valid, req_ready, out_nib_en, out_err}), 128'({1'b0, 1'b1, 16'h0, 1'b0}));
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && req_ready && out_nib_en == 0 && out_data == 0, "R9", "after reset",
              128'({out_valid, req_ready, out_nib_en}), 128'({1'b0, 1'b1, 16'h0}));

        send(0, 0, 0, 0, 0, 16'h00A5, 8'h11, 8'h22, "R1");
        send(0, 1, 1, 1, 1, 16'h1234, 8'h11, 8'h22, "R1");
        send(0, 0, 1, 1, 0, 16'h5A5A, 8'h33, 8'h44, "R10");
        send(1, 1, 0, 0, 0, 16'h00B1, 8'h5A, 8'hC3, "R2");
        send(1, 1, 0, 0, 1, 16'h8001, 8'hF0, 8'h0F, "R4");
        send(1, 1, 1, 1, 0, 16'h0080, 8'hAB, 8'hCD, "R10");
        send(1, 0, 0, 0, 0, 16'h00C6, 8'h7E, 8'h21, "R5");
        send(1, 0, 0, 1, 1, 16'hF00F, 8'h9C, 8'h36, "R3");
        send(1, 0, 1, 0, 1, 16'h8421, 8'h5B, 8'hE2, "R6");
        send(1, 0, 1, 1, 1, 16'hFFFF, 8'h11, 8'h22, "R7");
        send(1, 0, 1, 0, 0, 16'h00FF, 8'h11, 8'h22, "R7");
        send(1, 1, 0, 0, 1, 16'hFFFF, 8'h77, 8'h88, "R2");
        send(1, 0, 0, 0, 1, 16'h0000, 8'h77, 8'h88, "R2");
        send(1, 0, 1, 0, 1, 16'h0001, 8'hA6, 8'h03, "R6");
        send(1, 1, 0, 0, 0, 16'hFF01, 8'h44, 8'h99, "R3");

        rs = 32'h1D2C3B4A;
        for (int i = 0; i < 60; i++) begin
            rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
            send(rs[0] | rs[1], rs[2], rs[3], rs[4], rs[5], rs[31:16],
                 rs[15:8], rs[13:6] ^ 8'h5C, "R11");
        end
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(sbq.size() == 0, "R8", "all beats delivered", 128'(sbq.size()), 128'(0));
        check(!out_valid && req_ready, "R11", "idle at end",
              128'({out_valid, req_ready}), 128'({1'b0, 1'b1}));
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule